// File: doc/BRIEF.md
# Half-Bridge Alternating Pulse Generator

This block drives the two gate signals of a half-bridge. An internal oscillator counts out a period, in clock cycles, that follows a control word. A toggle stage hands successive oscillator cycles to output A and then to output B, so each output switches at half the oscillator rate. The last part of every oscillator cycle is a dead interval in which both outputs are held low. Because that interval is a fixed number of clocks, the duty cycle of each output drops below one half as the period shortens.

The control word acts only inside a window. At or below a lower threshold the oscillator runs at the programmed slowest period. Above that threshold, each extra step of control removes one clock from the period. The reduction stops growing at an upper threshold. The result is never shorter than the programmed fastest period, and never shorter than two clocks. The period and the dead time are captured only when an oscillator cycle begins, so a code change cannot cut a pulse short. A synchronous enable starts and stops pulsing. Every start begins with output A.

Top module: `hb_pulse_gen`

## Requirements
- R1: While reset is held, and after it is released with `en` low, `out_a`, `out_b` and `dt_bad` are all low.
- R2: `out_a` and `out_b` are never high in the same cycle. Successive oscillator cycles alternate between A and B.
- R3: An oscillator cycle lasts exactly P clocks, where P is the effective period captured at the start of that cycle. Each output therefore rises every 2·P clocks.
- R4: When `ctl` is at or below DZ_LO (default 200), P equals `per_slow`. With `per_slow`=40 this gives an A-to-A rise spacing of 80 clocks.
- R5: For DZ_LO < `ctl` ≤ DZ_HI, P = `per_slow` − (`ctl` − DZ_LO). With `ctl`=215 and `per_slow`=40, P is 25.
- R6: `ctl` values above DZ_HI (default 900) act as DZ_HI, and P is never less than `per_fast`. With `ctl`=1023 and `per_fast`=10, P is 10.
- R7: With dead code D < P, the selected output is high for the first P−D clocks of its oscillator cycle, and both outputs are low for the last D clocks.
- R8: `ctl`, `per_slow`, `per_fast` and `dt_code` are sampled only at the first clock of an oscillator cycle. A change in the middle of a cycle takes effect from the next cycle.
- R9: After a clock edge at which `en` is low, both outputs are low. The cycle count restarts, and the first pulse after `en` returns high is on `out_a`, starting in the first cycle.
- R10: While running with D ≥ P, both outputs stay low and `dt_bad` is high.
- R11: The effective period is never below 2 clocks. With `per_slow`=1, `per_fast`=0 and D=0, each output is high for 2 clocks and rises every 4 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Synchronous run enable |
| ctl | input | CTL_W (10) | Frequency control word; a higher value gives a shorter period |
| per_slow | input | PER_W (16) | Oscillator period in clocks at the lowest frequency |
| per_fast | input | PER_W (16) | Shortest allowed oscillator period in clocks |
| dt_code | input | DT_W (10) | Dead interval at the end of each oscillator cycle, in clocks |
| out_a | output | 1 | First-phase gate pulse |
| out_b | output | 1 | Second-phase gate pulse |
| dt_bad | output | 1 | High while running with a dead interval at or above the period |

## Verification
The bench targets control-code changes that land in the middle of a cycle. A design that resampled codes at once would make a pulse too short or too long against the reference model. Disabling while B is pulsing checks that the restart comes back on A: a design that kept its toggle state would open with B. The bench drives the control word through the dead zone, the linear region and saturation, and measures the spacing between rising edges. An off-by-one in the reduction or a missing clamp shows up as a wrong gap. A dead code equal to the period, and a degenerate period of two clocks, probe the window compare and the period floor. Getting either wrong produces stray pulses or a zero-length cycle.

// File: rtl/hbp_pkg.sv
`timescale 1ns/1ps
package hbp_pkg;

  // Effective oscillator period: slow period less the in-window control
  // excess, held at or above the fast limit and a two-clock floor.
  function automatic int unsigned hbp_eff_period(
    input int unsigned ctl,
    input int unsigned slow,
    input int unsigned fast,
    input int unsigned lo,
    input int unsigned hi
  );
    int unsigned c;
    int unsigned red;
    int unsigned r;
    c   = (ctl > hi) ? hi : ctl;
    red = (c > lo) ? (c - lo) : 0;
    r   = (slow > red) ? (slow - red) : 0;
    if (r < fast) r = fast;
    if (r < 2) r = 2;
    return r;
  endfunction

  // Gate window: open while the count sits before the dead slice.
  function automatic logic hbp_gate_open(
    input int unsigned cnt,
    input int unsigned per,
    input int unsigned dead
  );
    return (dead < per) && (cnt < (per - dead));
  endfunction

endpackage

// File: rtl/hbp_period_sel.sv
`timescale 1ns/1ps
module hbp_period_sel
  import hbp_pkg::*;
#(
  parameter int unsigned PER_W = 16,
  parameter int unsigned CTL_W = 10,
  parameter int unsigned DZ_LO = 200,
  parameter int unsigned DZ_HI = 900
) (
  input  logic [CTL_W-1:0] ctl,
  input  logic [PER_W-1:0] per_slow,
  input  logic [PER_W-1:0] per_fast,
  output logic [PER_W-1:0] per_eff
);

  always_comb begin
    per_eff = PER_W'(hbp_eff_period(32'(ctl), 32'(per_slow), 32'(per_fast),
                                    DZ_LO, DZ_HI));
  end

  // R4
  always_comb begin
    if ((32'(ctl) <= DZ_LO) && (per_slow >= per_fast) && (per_slow >= PER_W'(2)))
      dead_zone_chk: assert (per_eff == per_slow);
  end

  // R6
  always_comb begin
    fast_floor_chk: assert ((per_eff >= per_fast) && (per_eff >= PER_W'(2)));
  end

endmodule

// File: rtl/hbp_osc.sv
`timescale 1ns/1ps
module hbp_osc
  import hbp_pkg::*;
#(
  parameter int unsigned PER_W = 16,
  parameter int unsigned DT_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PER_W-1:0] per_eff,
  input  logic [DT_W-1:0]  dt_code,
  output logic             run,
  output logic             wrap,
  output logic             active,
  output logic             dt_bad
);

  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] p_lat;
  logic [DT_W-1:0]  d_lat;
  logic             cyc_start;

  assign wrap      = run && (cnt == (p_lat - ONE));
  assign cyc_start = en && (!run || wrap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      p_lat <= '0;
      d_lat <= '0;
    end else if (!en) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (cyc_start) begin
      run   <= 1'b1;
      cnt   <= '0;
      p_lat <= per_eff;
      d_lat <= dt_code;
    end else begin
      cnt <= cnt + ONE;
    end
  end

  always_comb begin
    active = run && hbp_gate_open(32'(cnt), 32'(p_lat), 32'(d_lat));
    dt_bad = run && (32'(d_lat) >= 32'(p_lat));
  end

  // R8
  codes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run && !wrap) |=> ($stable(p_lat) && $stable(d_lat)));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < p_lat));

  // R11
  per_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (p_lat >= PER_W'(2)));

  // R9
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!run && (cnt == '0)));

endmodule

// File: rtl/hbp_steer.sv
`timescale 1ns/1ps
module hbp_steer (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic run,
  input  logic wrap,
  input  logic active,
  output logic out_a,
  output logic out_b
);

  logic sel;

  always_ff @(posedge clk) begin
    if (!rst_n)          sel <= 1'b0;
    else if (!en)        sel <= 1'b0;
    else if (run && wrap) sel <= ~sel;
  end

  assign out_a = active && !sel;
  assign out_b = active && sel;

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && out_b));

  // R2
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wrap) |=> (sel != $past(sel)));

  // R9
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!out_a && !out_b && !sel));

endmodule

// File: rtl/hb_pulse_gen.sv
`timescale 1ns/1ps
module hb_pulse_gen #(
  parameter int unsigned PER_W = 16,
  parameter int unsigned DT_W  = 10,
  parameter int unsigned CTL_W = 10,
  parameter int unsigned DZ_LO = 200,
  parameter int unsigned DZ_HI = 900
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CTL_W-1:0] ctl,
  input  logic [PER_W-1:0] per_slow,
  input  logic [PER_W-1:0] per_fast,
  input  logic [DT_W-1:0]  dt_code,
  output logic             out_a,
  output logic             out_b,
  output logic             dt_bad
);

  logic [PER_W-1:0] per_eff;
  logic             run;
  logic             wrap;
  logic             active;

  hbp_period_sel #(
    .PER_W(PER_W), .CTL_W(CTL_W), .DZ_LO(DZ_LO), .DZ_HI(DZ_HI)
  ) u_per (
    .ctl(ctl), .per_slow(per_slow), .per_fast(per_fast), .per_eff(per_eff)
  );

  hbp_osc #(.PER_W(PER_W), .DT_W(DT_W)) u_osc (
    .clk(clk), .rst_n(rst_n), .en(en), .per_eff(per_eff), .dt_code(dt_code),
    .run(run), .wrap(wrap), .active(active), .dt_bad(dt_bad)
  );

  hbp_steer u_steer (
    .clk(clk), .rst_n(rst_n), .en(en), .run(run), .wrap(wrap),
    .active(active), .out_a(out_a), .out_b(out_b)
  );

  // R10
  bad_dead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dt_bad |-> (!out_a && !out_b));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_a && !out_b && !dt_bad));

endmodule

// File: tb/sim_hb_pulse_gen.sv
`timescale 1ns/1ps
module sim_hb_pulse_gen;

  localparam int LO = 200;
  localparam int HI = 900;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [9:0]  ctl = '0;
  logic [15:0] per_slow = 16'd40;
  logic [15:0] per_fast = 16'd10;
  logic [9:0]  dt_code = 10'd6;
  logic        out_a, out_b, dt_bad;

  hb_pulse_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .ctl(ctl), .per_slow(per_slow),
    .per_fast(per_fast), .dt_code(dt_code), .out_a(out_a), .out_b(out_b),
    .dt_bad(dt_bad)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  int m_run = 0, m_cnt = 0, m_sel = 0, m_p = 0, m_d = 0;
  // monitor state
  int cyc_n = 0, last_rise = -1, gap_a = 0, run_a = 0, len_a = 0;
  bit prev_a = 0, want_first = 0;

  function automatic int ref_period(int c, int slow, int fast);
    int r;
    if (c > HI) c = HI;
    r = slow;
    if (c > LO) r = slow - (c - LO);
    if (r < fast) r = fast;
    if (r < 2) r = 2;
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", tag, what, act, exp, cyc_n);
    end
  endtask

  task automatic model_step();
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_sel = 0; m_p = 0; m_d = 0;
    end else if (!en) begin
      m_run = 0; m_cnt = 0; m_sel = 0;
    end else if (m_run == 0 || m_cnt == m_p - 1) begin
      if (m_run != 0) m_sel = 1 - m_sel;
      m_run = 1; m_cnt = 0;
      m_p = ref_period(int'(ctl), int'(per_slow), int'(per_fast));
      m_d = int'(dt_code);
    end else begin
      m_cnt++;
    end
  endtask

  task automatic cyc(input string tag);
    int e_on;
    @(negedge clk);
    model_step();
    e_on = (m_run != 0 && m_d < m_p && m_cnt < m_p - m_d) ? 1 : 0;
    chk(tag, int'(out_a), (e_on != 0 && m_sel == 0) ? 1 : 0, "out_a vs model");
    chk(tag, int'(out_b), (e_on != 0 && m_sel == 1) ? 1 : 0, "out_b vs model");
    chk(tag, int'(dt_bad), (m_run != 0 && m_d >= m_p) ? 1 : 0, "dt_bad vs model");
    chk("R2", int'(out_a && out_b), 0, "outputs overlap");
    if (want_first && (out_a || out_b)) begin
      chk("R9", int'(out_a), 1, "first pulse after start is A");
      want_first = 0;
    end
    if (out_a && !prev_a) begin
      if (last_rise >= 0) gap_a = cyc_n - last_rise;
      last_rise = cyc_n;
    end
    if (out_a) run_a++;
    else if (prev_a) begin len_a = run_a; run_a = 0; end
    prev_a = out_a;
    cyc_n++;
  endtask

  initial begin
    repeat (4) cyc("R1");
    chk("R1", int'(out_a || out_b || dt_bad), 0, "quiet in reset");
    rst_n = 1'b1;
    repeat (2) cyc("R1");
    chk("R1", int'(out_a || out_b || dt_bad), 0, "quiet with en low");

    // dead zone: P=40, D=6
    ctl = 10'd100; en = 1'b1; want_first = 1;
    repeat (300) cyc("R3");
    chk("R4", gap_a, 80, "A rise spacing in dead zone");
    chk("R7", len_a, 34, "A width P-D");

    // linear region, changed mid-cycle: P=25
    ctl = 10'd215;
    repeat (300) cyc("R8");
    chk("R5", gap_a, 50, "A rise spacing at ctl=215");
    chk("R7", len_a, 19, "A width at P=25");

    // saturation: P=10, D=3
    ctl = 10'd1023; dt_code = 10'd3;
    repeat (200) cyc("R6");
    chk("R6", gap_a, 20, "A rise spacing saturated");
    chk("R7", len_a, 7, "A width at P=10");

    // stop during B pulse, restart
    while (!out_b) cyc("R9");
    en = 1'b0;
    cyc("R9");
    chk("R9", int'(out_a || out_b), 0, "low after en drop");
    repeat (4) cyc("R9");
    en = 1'b1; want_first = 1; last_rise = -1;
    cyc("R9");
    chk("R9", int'(out_a), 1, "A in first cycle after restart");
    repeat (100) cyc("R9");

    // dead code equal to period
    dt_code = 10'd10;
    repeat (100) cyc("R10");
    chk("R10", int'(dt_bad), 1, "flag with D>=P");
    chk("R10", int'(out_a || out_b), 0, "outputs low with D>=P");

    // two-clock floor
    per_slow = 16'd1; per_fast = 16'd0; dt_code = 10'd0;
    repeat (60) cyc("R11");
    chk("R11", gap_a, 4, "A rise spacing at floor");
    chk("R11", len_a, 2, "A width at floor");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule